// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

A watchdog peripheral on a 16-bit register bus. Software arms it by loading an 8-bit up-counter and turning on counting. If software does not reload the counter in time, the counter runs past 255. The block then latches an overflow flag and can drive a fixed-length reset pulse that restarts the system. The counter advances once per prescaled tick. A clock-select field picks the tick rate from a power-of-two divider on a free-running counter.

Every write is guarded. The upper byte of the written word must hold the key that belongs to the addressed register, or the write is dropped. The overflow flag has its own guard: a clear succeeds only after the flag has been seen set by a read. A runaway routine that writes blindly therefore cannot clear it.

The bus is a plain strobe interface with no back-pressure. A write or read takes effect in the cycle its strobe is high, and read data comes back combinationally from the address. There is no streamed data, so no valid/ready handshake is used.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the control register, the counter, the overflow flag and the reset-enable bit all read as zero, and the reset output is low.
- R2: A write to offset 0 updates the control register only when bits 15:8 equal 0xA5; otherwise nothing changes. Bit 6 selects watchdog mode, bit 5 enables counting, and bits SEL_W-1:0 form the clock select. Other bits read as zero, as does the upper byte of every read.
- R3: A write to offset 2 loads bits 7:0 into the counter only when bits 15:8 equal 0x5A. Any such load also restarts the prescaler, so a reload gives a full interval.
- R4: While bit 5 is set, the counter increments by one per prescaled tick. For SEL_W=3, codes 0 to 7 divide the clock by 2, 64, 128, 256, 512, 1024, 4096 and 16384. A counter loaded with N in the same cycle counting starts overflows after divisor times (256 − N) cycles.
- R5: Clearing bit 5 stops counting at once, and the counter holds its value.
- R6: At offset 4, a write whose bits 15:8 equal 0x5A copies bit 6 into the reset-enable bit. A read of offset 4 returns the overflow flag in bit 7 and reset-enable in bit 6.
- R7: An overflow in watchdog mode sets the overflow flag. In interval mode (bit 6 clear), an overflow sets no flag and drives no reset.
- R8: A write of exactly 0xA500 to offset 4 clears the overflow flag. The clear takes effect only if offset 4 has been read while the flag was set, at some point since the flag was last set; otherwise the flag stays set.
- R9: An overflow in watchdog mode with reset-enable set drives the reset output high for exactly RST_CYC (8) cycles. The output rises in the cycle after the overflowing tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms the flag clear) |
| bus_addr | input | 3 | Byte offset: 0 control, 2 counter, 4 reset control |
| bus_wdata | input | 16 | Write data: key in bits 15:8, value in bits 7:0 |
| bus_rdata | output | 16 | Read data for bus_addr, upper byte zero |
| wdt_rst_out | output | 1 | System reset pulse |

## Verification
The bench builds the block with SEL_W=3 and RST_CYC=8. The 3-bit select keeps the prescaler at 14 bits, so even the slowest code (divide by 16384) reaches overflow within the run, which lets the timing formula be checked at both ends of the divider table. An 8-cycle pulse keeps the width count short enough to check exactly. The divide-by-64 code is used to show that a mid-interval reload restarts the prescaler.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam logic [7:0]  KEY_CTL   = 8'hA5;
  localparam logic [7:0]  KEY_CNT   = 8'h5A;
  localparam logic [7:0]  KEY_RSTC  = 8'h5A;
  localparam logic [15:0] FLAG_WIPE = 16'hA500;
  localparam logic [2:0]  OFF_CTL   = 3'd0;
  localparam logic [2:0]  OFF_CNT   = 3'd2;
  localparam logic [2:0]  OFF_RSTC  = 3'd4;

  // Power-of-two shift applied by each clock-select code.
  function automatic int unsigned div_shift(int unsigned sel_w, int unsigned code);
    if (sel_w == 4) begin
      return (code == 0) ? 0 : code + 7;
    end
    case (code)
      0:       return 1;
      1:       return 6;
      2:       return 7;
      3:       return 8;
      4:       return 9;
      5:       return 10;
      6:       return 12;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/kwdt_decode.sv
module kwdt_decode (
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic        ctl_we,
  output logic        cnt_we,
  output logic        rste_we,
  output logic        wipe_req,
  output logic        rstc_rd
);
  import kwdt_pkg::*;

  logic [7:0] key;
  assign key = bus_wdata[15:8];

  always_comb begin
    ctl_we   = bus_wr && (bus_addr == OFF_CTL)  && (key == KEY_CTL);
    cnt_we   = bus_wr && (bus_addr == OFF_CNT)  && (key == KEY_CNT);
    rste_we  = bus_wr && (bus_addr == OFF_RSTC) && (key == KEY_RSTC);
    wipe_req = bus_wr && (bus_addr == OFF_RSTC) && (bus_wdata == FLAG_WIPE);
    rstc_rd  = bus_rd && (bus_addr == OFF_RSTC);
  end
endmodule

// File: rtl/kwdt_prescale.sv
module kwdt_prescale #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned CODES = 2 ** SEL_W;
  localparam int unsigned PRE_W = kwdt_pkg::div_shift(SEL_W, CODES - 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask_tab [CODES];

  for (genvar g = 0; g < CODES; g++) begin : g_mask
    localparam int unsigned SH = kwdt_pkg::div_shift(SEL_W, g);
    localparam logic [63:0] FULL = (64'd1 << SH) - 64'd1;
    assign mask_tab[g] = FULL[PRE_W-1:0];
  end

  logic [PRE_W-1:0] cur_mask;
  assign cur_mask = mask_tab[sel];
  assign tick     = run && ((pre_q & cur_mask) == cur_mask);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || restart) pre_q <= '0;
    else                           pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] TOP = '1;

  assign wrap = tick && !load && (cnt == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/kwdt_guard.sv
module kwdt_guard #(
  parameter int unsigned RST_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic wd_mode,
  input  logic rste_we,
  input  logic rste_d,
  input  logic wipe_req,
  input  logic rstc_rd,
  output logic flag_q,
  output logic arm_q,
  output logic rste_q,
  output logic rst_out
);
  localparam int unsigned PW = $clog2(RST_CYC + 1);

  logic          ovf_evt;
  logic [PW-1:0] pulse_q;

  assign ovf_evt = wrap && wd_mode;
  assign rst_out = (pulse_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (ovf_evt) begin
      flag_q <= 1'b1;
      arm_q  <= 1'b0;
    end else begin
      if (rstc_rd && flag_q) arm_q <= 1'b1;
      if (wipe_req && arm_q) begin
        flag_q <= 1'b0;
        arm_q  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rste_q <= 1'b0;
    else if (rste_we) rste_q <= rste_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 pulse_q <= '0;
    else if (ovf_evt && rste_q) pulse_q <= PW'(RST_CYC);
    else if (pulse_q != '0)     pulse_q <= pulse_q - 1'b1;
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned RST_CYC = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        wdt_rst_out
);
  import kwdt_pkg::*;

  localparam int unsigned BIT_WD  = 6;
  localparam int unsigned BIT_EN  = 5;
  localparam logic [7:0]  CTL_MSK = 8'h60 | 8'((1 << SEL_W) - 1);

  logic       ctl_we, cnt_we, rste_we, wipe_req, rstc_rd;
  logic [7:0] ctl_q;
  logic [7:0] cnt_q;
  logic       pre_tick, wrap_evt;
  logic       flag_q, arm_q, rste_q;

  kwdt_decode u_dec (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .ctl_we(ctl_we), .cnt_we(cnt_we), .rste_we(rste_we),
    .wipe_req(wipe_req), .rstc_rd(rstc_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= bus_wdata[7:0] & CTL_MSK;
  end

  kwdt_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctl_q[BIT_EN]), .restart(cnt_we),
    .sel(ctl_q[SEL_W-1:0]), .tick(pre_tick)
  );

  kwdt_counter #(.CNT_W(8)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(pre_tick), .load(cnt_we),
    .load_val(bus_wdata[7:0]), .cnt(cnt_q), .wrap(wrap_evt)
  );

  kwdt_guard #(.RST_CYC(RST_CYC)) u_grd (
    .clk(clk), .rst_n(rst_n), .wrap(wrap_evt), .wd_mode(ctl_q[BIT_WD]),
    .rste_we(rste_we), .rste_d(bus_wdata[6]), .wipe_req(wipe_req), .rstc_rd(rstc_rd),
    .flag_q(flag_q), .arm_q(arm_q), .rste_q(rste_q), .rst_out(wdt_rst_out)
  );

  always_comb begin
    case (bus_addr)
      OFF_CTL:  bus_rdata = {8'h00, ctl_q};
      OFF_CNT:  bus_rdata = {8'h00, cnt_q};
      OFF_RSTC: bus_rdata = {8'h00, flag_q, rste_q, 6'b0};
      default:  bus_rdata = 16'h0000;
    endcase
  end
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(
  parameter int unsigned RST_CYC = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [2:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic [7:0]  ctl_q,
  input logic [7:0]  cnt_q,
  input logic        pre_tick,
  input logic        cnt_we,
  input logic        flag_q,
  input logic        arm_q,
  input logic        rste_q,
  input logic        wrap_evt,
  input logic        wdt_rst_out
);
  int unsigned hi_run;

  always_ff @(posedge clk) begin
    if (!rst_n || !wdt_rst_out || (wrap_evt && ctl_q[6])) hi_run <= 0;
    else                                                  hi_run <= hi_run + 1;
  end

  // R2
  ctl_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0 && bus_wdata[15:8] != 8'hA5) |=> $stable(ctl_q));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[5] && !cnt_we) |=> $stable(cnt_q));

  // R4
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_tick && !cnt_we) |=> (cnt_q == $past(cnt_q) + 8'd1));

  // R8
  clear_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(arm_q));

  // R9
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_out) |-> $past(wrap_evt && ctl_q[6] && rste_q));

  // R9
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_out |-> (hi_run < RST_CYC));
endmodule

bind keyed_watchdog keyed_watchdog_chk #(.RST_CYC(RST_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .ctl_q(ctl_q), .cnt_q(cnt_q), .pre_tick(pre_tick), .cnt_we(cnt_we),
  .flag_q(flag_q), .arm_q(arm_q), .rste_q(rste_q), .wrap_evt(wrap_evt),
  .wdt_rst_out(wdt_rst_out)
);

// File: tb/keyed_watchdog_bench.sv
`timescale 1ns/1ps
module keyed_watchdog_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        wdt_rst_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t sb_q[$];

  always #5 clk = ~clk;

  keyed_watchdog #(.SEL_W(3), .RST_CYC(8)) u_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst_out(wdt_rst_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, input logic [15:0] exp, input string tag);
    rd_item_t it;
    @(negedge clk);
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Monitor: compare read data against the scoreboard queue.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (bus_rd) begin
        if (sb_q.size() == 0) begin
          check("monitor underflow", 1, 0);
        end else begin
          rd_item_t it;
          it = sb_q.pop_front();
          check(it.tag, int'(bus_rdata), int'(it.exp));
        end
      end
    end
  end

  // Count negedges until the reset output is seen high.
  task automatic time_to_rst(input int limit, output int n);
    n = 0;
    while (!wdt_rst_out && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse_width(output int w);
    w = 0;
    while (wdt_rst_out && w < 100) begin
      @(negedge clk);
      w++;
    end
  endtask

  task automatic quiet_for(input int cyc, input string tag);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (wdt_rst_out) seen = 1;
    end
    check(tag, seen, 0);
  endtask

  initial begin
    int n, w;
    repeat (3) @(negedge clk);
    check("R1 reset output low", int'(wdt_rst_out), 0);
    rst_n = 1'b1;
    bus_read(3'd0, 16'h0000, "R1 control after reset");
    bus_read(3'd2, 16'h0000, "R1 counter after reset");
    bus_read(3'd4, 16'h0000, "R1 reset control after reset");

    // Keys
    bus_write(3'd0, 16'h5A65);
    bus_read(3'd0, 16'h0000, "R2 control ignores wrong key");
    bus_write(3'd2, 16'hA533);
    bus_read(3'd2, 16'h0000, "R3 counter ignores wrong key");
    bus_write(3'd2, 16'h5A33);
    bus_read(3'd2, 16'h0033, "R3 counter keyed load");
    bus_write(3'd0, 16'hA5C7);
    bus_read(3'd0, 16'h0047, "R2 control fields masked");
    bus_write(3'd4, 16'h5A40);
    bus_read(3'd4, 16'h0040, "R6 reset enable set");
    bus_write(3'd4, 16'hA540);
    bus_read(3'd4, 16'h0040, "R6 wrong key leaves reset control");

    // Overflow timing at fastest code: 2*(256-250) = 12
    bus_write(3'd2, 16'h5AFA);
    bus_write(3'd0, 16'hA560);
    time_to_rst(100, n);
    check("R4 overflow time code 0", n, 12);
    pulse_width(w);
    check("R9 reset pulse width", w, 8);
    bus_write(3'd0, 16'hA500);
    bus_write(3'd4, 16'hA500);
    bus_read(3'd4, 16'h00C0, "R8 clear without prior read ignored");
    bus_write(3'd4, 16'hA500);
    bus_read(3'd4, 16'h0040, "R8 clear after read");

    // Stop holds the counter: ticks at 5 edges then stop
    bus_write(3'd2, 16'h5A10);
    bus_write(3'd0, 16'hA520);
    repeat (9) @(negedge clk);
    bus_write(3'd0, 16'hA500);
    bus_read(3'd2, 16'h0015, "R5 counter value at stop");
    repeat (20) @(negedge clk);
    bus_read(3'd2, 16'h0015, "R5 counter holds while stopped");

    // Interval mode: overflow without flag or reset
    bus_write(3'd2, 16'h5AFE);
    bus_write(3'd0, 16'hA520);
    quiet_for(30, "R7 no reset in interval mode");
    bus_write(3'd0, 16'hA500);
    bus_read(3'd4, 16'h0040, "R7 no flag in interval mode");

    // Reload mid-interval restarts the prescaler: 64*(256-254) = 128
    bus_write(3'd2, 16'h5AFE);
    bus_write(3'd0, 16'hA561);
    repeat (40) @(negedge clk);
    bus_write(3'd2, 16'h5AFE);
    time_to_rst(400, n);
    check("R3 reload gives full interval", n, 128);
    pulse_width(w);
    check("R9 pulse width code 1", w, 8);
    bus_write(3'd0, 16'hA500);
    bus_read(3'd4, 16'h00C0, "R7 flag set on watchdog overflow");
    bus_write(3'd4, 16'hA500);
    bus_read(3'd4, 16'h0040, "R8 clear after arming read");

    // Slowest code: 16384*(256-255)
    bus_write(3'd2, 16'h5AFF);
    bus_write(3'd0, 16'hA567);
    time_to_rst(20000, n);
    check("R4 overflow time code 7", n, 16384);
    pulse_width(w);
    bus_write(3'd0, 16'hA500);
    bus_read(3'd4, 16'h00C0, "R7 flag after slow overflow");
    bus_write(3'd4, 16'hA500);

    // Reset enable off: flag only
    bus_write(3'd4, 16'h5A00);
    bus_read(3'd4, 16'h0000, "R6 reset enable cleared");
    bus_write(3'd2, 16'h5AFE);
    bus_write(3'd0, 16'hA560);
    quiet_for(30, "R9 no pulse with reset disabled");
    bus_write(3'd0, 16'hA500);
    bus_read(3'd4, 16'h0080, "R7 flag set with reset disabled");

    repeat (4) @(negedge clk);
    check("scoreboard drained", sb_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule